// File: doc/BRIEF.md
# Indexed Bank Select Register File

This block sits on the cartridge side of a small computer and turns a narrow CPU write port into a set of eight bank registers. Software first writes a register number to an even address in the $8000–$9FFF range, then writes a bank number to an odd address in the same range. The second write lands in whichever register the last number chose. The register number is kept until the next write of that kind, so one choice can be followed by any number of data writes.

Two of the registers steer the lower two 8 KB CPU program windows. The two upper windows always point at the last two 8 KB banks of the program ROM. The remaining six registers steer the pattern-table windows of the picture processor. Register 0 and register 1 each select a 2 KB window, and registers 2 to 5 each select a 1 KB window. Both ROM addresses are computed combinationally from the registers and the incoming bus addresses. Writes take effect strictly in bus order. The block has no knowledge of which code path issued a write, so a register-number write slipped in by another routine redirects every later data write.

Top module: `bank_select_regs`

## Requirements
- R1: A write (cpu_wr high at a rising clock edge) whose address has bits 15:13 equal to 100 and bit 0 equal to 0 loads the register index from the low three data bits.
- R2: A write with address bits 15:13 equal to 100 and bit 0 equal to 1 stores the full data byte into the bank register chosen by the current index.
- R3: The index keeps its value across data writes, idle cycles and writes to other addresses. Only the next index write changes it.
- R4: If one index write is followed by a second index write and a data write, a further lone data write updates the register chosen by the second index. The register chosen by the first index keeps its value.
- R5: For CPU addresses $8000–$9FFF, prg_addr equals bank register 6 (its low PRG_BANK_W bits) concatenated with cpu_addr[12:0].
- R6: For CPU addresses $A000–$BFFF, prg_addr equals bank register 7 (its low PRG_BANK_W bits) concatenated with cpu_addr[12:0].
- R7: For $C000–$DFFF the bank field of prg_addr is the second-to-last bank (all ones minus one). For $E000–$FFFF it is the last bank (all ones). The offset is cpu_addr[12:0] in both cases.
- R8: For ppu_addr[12]=0, chr_addr is {register 0 when ppu_addr[11]=0 or register 1 when it is 1, with its bit 0 dropped, ppu_addr[10:0]}. For ppu_addr[12]=1, chr_addr is {register 2+ppu_addr[11:10], ppu_addr[9:0]}.
- R9: Writes whose address bits 15:13 are not 100, and cycles with cpu_wr low, change neither the index nor any bank register.
- R10: Synchronous reset clears the index and all eight bank registers to zero.
- R11: Index data bits 7:3 are ignored. For example, a data value of $F9 selects register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_addr | input | 16 | CPU address for writes and program mapping |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | Picture processor pattern-space address |
| prg_addr | output | PRG_BANK_W+13 | Program ROM byte address |
| chr_addr | output | CHR_BANK_W+10 | Pattern ROM byte address |

## Verification
Each of the eight registers is loaded through its own index and data pair with a distinct value. After each load, the program space $8000–$FFFF and the pattern space are swept. These sweeps separate each window's register from its neighbours and from the fixed banks, and they expose wrong offset splicing at the 1 KB and 2 KB boundaries. Further patterns cover the following cases:
- index values with high bits set, which show whether only three bits are decoded;
- writes outside the decode range, which must leave every register unchanged;
- an interleaved select sequence, which shows that a later data write follows the most recent index.

A data write straight after reset checks that the index starts at zero.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
    localparam int NUM_REGS  = 8;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int DATA_W    = 8;
    localparam int PRG_OFS_W = 13;
    localparam int CHR_OFS_W = 10;
    localparam int NUM_CHR   = 6;
    localparam int PRG_REG_LO = 6;
    localparam int PRG_REG_HI = 7;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_INDEX = 2'd1,
        OP_DATA  = 2'd2
    } bus_op_e;

    typedef struct packed {
        bus_op_e           op;
        logic [DATA_W-1:0] data;
    } bus_cmd_t;

    function automatic bus_op_e classify(input logic wr, input logic [2:0] top3, input logic a0);
        if (!wr || top3 != 3'b100) return OP_NONE;
        return a0 ? OP_DATA : OP_INDEX;
    endfunction
endpackage

// File: rtl/bsel_decode.sv
module bsel_decode
    import bsel_pkg::*;
(
    input  logic              wr,
    input  logic [15:0]       addr,
    input  logic [DATA_W-1:0] data,
    output bus_cmd_t          cmd
);
    logic unused_addr_bits;
    assign unused_addr_bits = ^addr[12:1];

    always_comb begin
        cmd.op   = classify(wr, addr[15:13], addr[0]);
        cmd.data = data;
    end
endmodule

// File: rtl/bsel_regfile.sv
module bsel_regfile
    import bsel_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  bus_cmd_t                   cmd,
    output logic [IDX_W-1:0]           idx_q,
    output logic [NUM_REGS*DATA_W-1:0] bank_flat
);
    logic unused_idx_bits;
    assign unused_idx_bits = ^cmd.data[DATA_W-1:IDX_W];

    always_ff @(posedge clk) begin
        if (rst)                    idx_q <= '0;
        else if (cmd.op == OP_INDEX) idx_q <= cmd.data[IDX_W-1:0];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
        logic [DATA_W-1:0] bank_q;
        always_ff @(posedge clk) begin
            if (rst)
                bank_q <= '0;
            else if (cmd.op == OP_DATA && idx_q == IDX_W'(g))
                bank_q <= cmd.data;
        end
        assign bank_flat[g*DATA_W +: DATA_W] = bank_q;
    end
endmodule

// File: rtl/bsel_prg_map.sv
module bsel_prg_map
    import bsel_pkg::*;
#(
    parameter int PRG_BANK_W = 6
) (
    input  logic [DATA_W-1:0]               bank_lo,
    input  logic [DATA_W-1:0]               bank_hi,
    input  logic [15:0]                     cpu_addr,
    output logic [PRG_BANK_W+PRG_OFS_W-1:0] prg_addr
);
    localparam logic [PRG_BANK_W-1:0] LAST_BANK   = '1;
    localparam logic [PRG_BANK_W-1:0] PENULT_BANK = LAST_BANK - 1'b1;

    logic [PRG_BANK_W-1:0] win_bank;
    logic                  unused_prg;

    if (PRG_BANK_W < DATA_W) begin : g_trim
        assign unused_prg = ^{bank_lo[DATA_W-1:PRG_BANK_W], bank_hi[DATA_W-1:PRG_BANK_W], cpu_addr[15]};
    end else begin : g_full
        assign unused_prg = cpu_addr[15];
    end

    always_comb begin
        unique case (cpu_addr[14:13])
            2'b00:   win_bank = bank_lo[PRG_BANK_W-1:0];
            2'b01:   win_bank = bank_hi[PRG_BANK_W-1:0];
            2'b10:   win_bank = PENULT_BANK;
            default: win_bank = LAST_BANK;
        endcase
        prg_addr = {win_bank, cpu_addr[PRG_OFS_W-1:0]};
    end
endmodule

// File: rtl/bsel_chr_map.sv
module bsel_chr_map
    import bsel_pkg::*;
#(
    parameter int CHR_BANK_W = 8
) (
    input  logic [NUM_CHR*DATA_W-1:0]       chr_banks,
    input  logic [12:0]                     ppu_addr,
    output logic [CHR_BANK_W+CHR_OFS_W-1:0] chr_addr
);
    logic [DATA_W-1:0] big_sel;
    logic [DATA_W-1:0] small_sel;
    logic [2:0]        small_idx;
    logic              unused_chr;

    if (CHR_BANK_W < DATA_W) begin : g_trim
        assign unused_chr = ^{big_sel[DATA_W-1:CHR_BANK_W], small_sel[DATA_W-1:CHR_BANK_W], big_sel[0]};
    end else begin : g_full
        assign unused_chr = big_sel[0];
    end

    always_comb begin
        small_idx = 3'd2 + {1'b0, ppu_addr[11:10]};
        big_sel   = chr_banks[{2'b00, ppu_addr[11]}*DATA_W +: DATA_W];
        small_sel = chr_banks[small_idx*DATA_W +: DATA_W];
        if (!ppu_addr[12])
            chr_addr = {big_sel[CHR_BANK_W-1:1], ppu_addr[10:0]};
        else
            chr_addr = {small_sel[CHR_BANK_W-1:0], ppu_addr[9:0]};
    end
endmodule

// File: rtl/bank_select_regs.sv
module bank_select_regs
    import bsel_pkg::*;
#(
    parameter int PRG_BANK_W = 6,
    parameter int CHR_BANK_W = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cpu_wr,
    input  logic [15:0]                     cpu_addr,
    input  logic [7:0]                      cpu_data,
    input  logic [12:0]                     ppu_addr,
    output logic [PRG_BANK_W+PRG_OFS_W-1:0] prg_addr,
    output logic [CHR_BANK_W+CHR_OFS_W-1:0] chr_addr
);
    bus_cmd_t                   cmd;
    logic [IDX_W-1:0]           idx_q;
    logic [NUM_REGS*DATA_W-1:0] bank_flat;

    bsel_decode u_decode (
        .wr   (cpu_wr),
        .addr (cpu_addr),
        .data (cpu_data),
        .cmd  (cmd)
    );

    bsel_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .idx_q     (idx_q),
        .bank_flat (bank_flat)
    );

    bsel_prg_map #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
        .bank_lo  (bank_flat[PRG_REG_LO*DATA_W +: DATA_W]),
        .bank_hi  (bank_flat[PRG_REG_HI*DATA_W +: DATA_W]),
        .cpu_addr (cpu_addr),
        .prg_addr (prg_addr)
    );

    bsel_chr_map #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
        .chr_banks (bank_flat[NUM_CHR*DATA_W-1:0]),
        .ppu_addr  (ppu_addr),
        .chr_addr  (chr_addr)
    );
endmodule

// File: rtl/bank_select_regs_chk.sv
module bank_select_regs_chk #(
    parameter int PRG_BANK_W = 6
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cpu_wr,
    input logic [15:0]             cpu_addr,
    input logic [7:0]              cpu_data,
    input logic [PRG_BANK_W+12:0]  prg_addr,
    input logic [2:0]              idx_q,
    input logic [63:0]             bank_flat
);
    logic in_win;
    assign in_win = cpu_addr[15:13] == 3'b100;

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && in_win && !cpu_addr[0]) |=> idx_q == $past(cpu_data[2:0])); // R1
    AST_DATA_STORE: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && in_win && cpu_addr[0]) |=> bank_flat[$past(idx_q)*8 +: 8] == $past(cpu_data)); // R2
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && in_win && !cpu_addr[0]) |=> $stable(idx_q)); // R3
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && in_win) |=> $stable(bank_flat)); // R9
    AST_WIN_LOW: assert property (@(posedge clk) disable iff (rst)
        in_win |-> prg_addr[PRG_BANK_W+12:13] == bank_flat[48 +: PRG_BANK_W]); // R5
    AST_WIN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b101) |-> prg_addr[PRG_BANK_W+12:13] == bank_flat[56 +: PRG_BANK_W]); // R6
    AST_FIXED_LAST: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b111) |-> &prg_addr[PRG_BANK_W+12:13]); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $fell(rst) |-> (idx_q == 3'd0 && bank_flat == 64'd0)); // R10
endmodule

bind bank_select_regs bank_select_regs_chk #(.PRG_BANK_W(PRG_BANK_W)) u_chk (.*);

// File: tb/bank_select_regs_bench.sv
module bank_select_regs_bench;
    localparam int PW = 6;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_wr = 1'b0;
    logic [15:0]   cpu_addr = 16'h0000;
    logic [7:0]    cpu_data = 8'h00;
    logic [12:0]   ppu_addr = 13'h0;
    logic [PW+12:0] prg_addr;
    logic [CW+9:0]  chr_addr;

    int total = 0;
    int bad = 0;
    logic [7:0] m_bank [8];
    logic [2:0] m_idx;

    always #10 clk = ~clk;

    bank_select_regs #(.PRG_BANK_W(PW), .CHR_BANK_W(CW)) u_bank_select_regs (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr)
    );

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a[15:13] == 3'b100) begin
            if (!a[0]) m_idx = d[2:0];
            else       m_bank[m_idx] = d;
        end
    endtask

    function automatic logic [PW+12:0] exp_prg(input logic [15:0] a);
        logic [PW-1:0] b;
        case (a[14:13])
            2'b00:   b = m_bank[6][PW-1:0];
            2'b01:   b = m_bank[7][PW-1:0];
            2'b10:   b = {PW{1'b1}} - 1'b1;
            default: b = {PW{1'b1}};
        endcase
        return {b, a[12:0]};
    endfunction

    function automatic logic [CW+9:0] exp_chr(input logic [12:0] p);
        logic [7:0] b;
        if (!p[12]) begin
            b = m_bank[{2'b00, p[11]}];
            return {b[CW-1:1], p[10], p[9:0]};
        end
        b = m_bank[3'd2 + {1'b0, p[11:10]}];
        return {b[CW-1:0], p[9:0]};
    endfunction

    task automatic sweep(input string tag);
        for (int a = 32'h8000; a <= 32'hFFFF; a += 97) begin
            cpu_addr = a[15:0];
            #1;
            check($sformatf("R5/R6/R7 %s a=%h", tag, a[15:0]), 32'(prg_addr), 32'(exp_prg(a[15:0])));
        end
        for (int p = 0; p < 8192; p += 29) begin
            ppu_addr = p[12:0];
            #1;
            check($sformatf("R8 %s p=%h", tag, p[12:0]), 32'(chr_addr), 32'(exp_chr(p[12:0])));
        end
        cpu_addr = 16'h0000;
    endtask

    initial begin
        m_idx = 3'd0;
        for (int i = 0; i < 8; i++) m_bank[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        sweep("R10 reset");
        // R10: index starts at zero, so a bare data write lands in register 0
        bus_write(16'h8001, 8'h2C);
        ppu_addr = 13'h0000; #1;
        check("R10 idx zero", 32'(chr_addr), 32'({8'h2C, 10'h0} ));
        // R1 R2: every register through its own pair
        for (int i = 0; i < 8; i++) begin
            bus_write(16'h8000 | 16'((i * 16'h246) & 16'h1FFE), 8'(i));
            bus_write(16'h9FFF, 8'((i * 37 + 11) ^ 8'hA5));
            sweep($sformatf("R1 R2 reg%0d", i));
        end
        // R11: high index bits ignored
        bus_write(16'h8000, 8'hF9);
        bus_write(16'h8001, 8'h6E);
        ppu_addr = 13'h0BFF; #1;
        check("R11 F9 selects reg1", 32'(chr_addr), 32'({7'h37, 11'h3FF}));
        // R9 and R3: stray writes leave state alone, index persists
        bus_write(16'h8000, 8'd6);
        bus_write(16'hA000, 8'h11);
        bus_write(16'hC001, 8'h12);
        bus_write(16'h7FFF, 8'h13);
        bus_write(16'hE000, 8'h05);
        cpu_addr = 16'h8000; #1;
        check("R9 stray writes", 32'(prg_addr), 32'(exp_prg(16'h8000)));
        bus_write(16'h8001, 8'h15);
        bus_write(16'h8003, 8'h16);
        cpu_addr = 16'h9234; #1;
        check("R3 index persists", 32'(prg_addr), 32'({6'h16, 13'h1234}));
        // R4: interleaved select/data pair retargets the later data write
        bus_write(16'h8000, 8'd6);
        bus_write(16'h8000, 8'd7);
        bus_write(16'h8001, 8'h21);
        bus_write(16'h8001, 8'h2A);
        cpu_addr = 16'hA010; #1;
        check("R4 reg7 gets lone write", 32'(prg_addr), 32'({6'h2A, 13'h0010}));
        cpu_addr = 16'h8010; #1;
        check("R4 reg6 untouched", 32'(prg_addr), 32'({6'h16, 13'h0010}));
        // R7: fixed windows with all-ones data elsewhere
        bus_write(16'h8000, 8'd2);
        bus_write(16'h8001, 8'hFF);
        cpu_addr = 16'hC000; #1;
        check("R7 penultimate", 32'(prg_addr), 32'({6'h3E, 13'h0000}));
        cpu_addr = 16'hFFFF; #1;
        check("R7 last", 32'(prg_addr), 32'({6'h3F, 13'h1FFF}));
        sweep("final");
        finish_run();
    end
endmodule